// File: doc/BRIEF.md
# Split/Chained Timer-Counter with Capture

This block is a 16-bit up-counter made of two 8-bit halves. A two-bit mode input selects how the halves are used. They can run as two separate prescaled timers, as a prescaled timer beside an event counter, as one chained 16-bit prescaled timer, or as one 16-bit event counter. The prescaler is an 8-bit down-divider whose reload value software sets. The event source is a single-cycle strobe that is already synchronous to the clock.

Each counting structure compares its count against a match value. After it reaches that value, the next tick returns it to zero and raises a sticky match flag, which software clears by writing a one. Two capture strobes copy the live count into holding registers. The width of the copy follows the mode: 8 bits per half when the halves run apart, and the full 16 bits when they are chained. Configuration, enables, flag clears and capture readback are plain ports, so a register file outside the block can map them as it needs.

Top module: `capture_timer16`

## Requirements
- R1: After reset both capture registers read zero and both match flags are clear.
- R2: The prescaler yields one tick every (preReload+1) clock cycles, so a reload of 0 ticks every cycle. It restarts from zero whenever no prescaled half is running, which puts the first tick (preReload+1) cycles after the run enable is seen.
- R3: In mode 0 (mode=2'd0) each half counts prescaled ticks under its own run enable. A half that ticks while equal to its match value goes to zero on that tick and sets its own flag: matchFlag[0] for the low half, matchFlag[1] for the high half.
- R4: In mode 1 (mode=2'd1) the low half counts prescaled ticks and the high half counts clock cycles in which eventIn is high while runHi is set.
- R5: In mode 2 (mode=2'd2) the halves chain into one 16-bit count of prescaled ticks, enabled by runLo and compared against {matchHi,matchLo}. Only matchFlag[0] can be set in this mode; a low-byte-only equality sets nothing.
- R6: In mode 3 (mode=2'd3) the chained 16-bit count advances once per cycle with eventIn high while runLo is set; the prescaler has no effect on it.
- R7: In modes 0 and 1, capStbLo loads capLo with the low count as it stood before that clock edge, and capStbHi does the same for capHi from the high count.
- R8: In modes 2 and 3, either capture strobe loads both capture registers with the full 16-bit count as it stood before that edge.
- R9: A one in flagClr bit i clears matchFlag[i], and a zero bit leaves its flag alone. When a set and a clear land on the same edge, the flag ends up set.
- R10: A half whose run enable is low is held at zero. In modes 2 and 3 runLo governs both halves and runHi is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Structure select, 0..3 |
| preReload | input | 8 | Prescaler reload, divide by value+1 |
| matchLo | input | 8 | Low half / low byte match value |
| matchHi | input | 8 | High half / high byte match value |
| runLo | input | 1 | Run enable of low half (whole counter in modes 2, 3) |
| runHi | input | 1 | Run enable of high half (modes 0, 1) |
| eventIn | input | 1 | Synchronous external event strobe |
| capStbLo | input | 1 | Low capture strobe |
| capStbHi | input | 1 | High capture strobe |
| flagClr | input | 2 | Write-one-to-clear for the match flags |
| capLo | output | 8 | Low capture register |
| capHi | output | 8 | High capture register |
| matchFlag | output | 2 | Sticky match flags, bit 0 low/wide, bit 1 high |

## Verification
The assertions assume that eventIn, the capture strobes and flagClr are already synchronous to clk. They also assume that mode changes only while both run enables are low, so the properties tying a count to its hold, flags and capture registers never cross a reconfiguration in mid-count. The directed tasks keep to this by going through a quiesce step before every mode or reload change. That step drops both enables and clears both flags. All strobes are driven between clock edges and last exactly one cycle, except where a task holds an event or clear high on purpose across several edges.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    MODE_DUAL  = 2'd0,
    MODE_MIXED = 2'd1,
    MODE_WIDE  = 2'd2,
    MODE_EVT16 = 2'd3
  } ctmrMode_e;

  // Strobes from control to datapath, valid for one cycle each.
  typedef struct packed {
    logic tickLo;   // advance low half (or the chained count)
    logic tickHi;   // advance high half in split modes
    logic holdLo;   // force low half to zero
    logic holdHi;   // force high half to zero
    logic chained;  // halves act as one 16-bit counter
  } ctmrStb_t;

endpackage

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl
  import ctmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctmrMode_e        mode,
  input  logic [PRE_W-1:0] preReload,
  input  logic             runLo,
  input  logic             runHi,
  input  logic             eventIn,
  output ctmrStb_t         stb
);

  localparam logic [PRE_W-1:0] ONE_P = 1;

  logic [PRE_W-1:0] preCnt;
  logic             preRun;
  logic             preTick;

  // Prescaler runs while any half that uses it is enabled.
  assign preRun  = runLo | ((mode == MODE_DUAL) & runHi);
  assign preTick = preRun & (preCnt >= preReload);

  always_ff @(posedge clk) begin
    if (!rstN)                 preCnt <= '0;
    else if (!preRun || preTick) preCnt <= '0;
    else                       preCnt <= preCnt + ONE_P;
  end

  always_comb begin
    stb = '0;
    unique case (mode)
      MODE_DUAL: begin
        stb.tickLo = runLo & preTick;
        stb.tickHi = runHi & preTick;
        stb.holdLo = !runLo;
        stb.holdHi = !runHi;
      end
      MODE_MIXED: begin
        stb.tickLo = runLo & preTick;
        stb.tickHi = runHi & eventIn;
        stb.holdLo = !runLo;
        stb.holdHi = !runHi;
      end
      MODE_WIDE: begin
        stb.tickLo  = runLo & preTick;
        stb.holdLo  = !runLo;
        stb.holdHi  = !runLo;
        stb.chained = 1'b1;
      end
      default: begin
        stb.tickLo  = runLo & eventIn;
        stb.holdLo  = !runLo;
        stb.holdHi  = !runLo;
        stb.chained = 1'b1;
      end
    endcase
  end

  AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    preTick |=> (preCnt == '0)); // R2

endmodule

// File: rtl/ctmr_dpath.sv
module ctmr_dpath
  import ctmr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctmrStb_t          stb,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  input  logic              capStbLo,
  input  logic              capStbHi,
  input  logic [1:0]        flagClr,
  output logic [HALF_W-1:0] capLo,
  output logic [HALF_W-1:0] capHi,
  output logic [1:0]        matchFlag
);

  localparam int FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] ONE_H = 1;
  localparam logic [FULL_W-1:0] ONE_W = 1;

  logic [1:0][HALF_W-1:0] cnt;
  logic [1:0][HALF_W-1:0] cntNext;
  logic [1:0][HALF_W-1:0] cap;
  logic [1:0][HALF_W-1:0] matchVal;
  logic [1:0][HALF_W-1:0] splitNext;
  logic [1:0]             splitHit;
  logic [1:0]             halfTick;
  logic [1:0]             halfHold;
  logic [1:0]             capStb;
  logic [1:0]             setFlag;
  logic [FULL_W-1:0]      cntWide;
  logic [FULL_W-1:0]      wideNext;
  logic                   wideHit;

  assign matchVal = {matchHi, matchLo};
  assign halfTick = {stb.tickHi, stb.tickLo};
  assign halfHold = {stb.holdHi, stb.holdLo};
  assign capStb   = {capStbHi, capStbLo};

  // Per-half comparison and successor for the split modes.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign splitHit[h]  = (cnt[h] == matchVal[h]);
    assign splitNext[h] = splitHit[h] ? '0 : cnt[h] + ONE_H;
  end

  assign cntWide  = {cnt[1], cnt[0]};
  assign wideHit  = (cntWide == {matchHi, matchLo});
  assign wideNext = wideHit ? '0 : cntWide + ONE_W;

  always_comb begin
    cntNext = cnt;
    setFlag = '0;
    if (stb.chained) begin
      if (stb.tickLo) cntNext = wideNext;
      setFlag[0] = stb.tickLo & wideHit;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (halfTick[h]) cntNext[h] = splitNext[h];
        setFlag[h] = halfTick[h] & splitHit[h];
      end
    end
    for (int h = 0; h < 2; h++)
      if (halfHold[h]) cntNext[h] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      cap       <= '0;
      matchFlag <= '0;
    end else begin
      cnt <= cntNext;
      if (stb.chained) begin
        if (|capStb) cap <= cnt;
      end else begin
        for (int h = 0; h < 2; h++)
          if (capStb[h]) cap[h] <= cnt[h];
      end
      for (int h = 0; h < 2; h++) begin
        if (setFlag[h])      matchFlag[h] <= 1'b1;
        else if (flagClr[h]) matchFlag[h] <= 1'b0;
      end
    end
  end

  assign capLo = cap[0];
  assign capHi = cap[1];

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdLo |=> (cnt[0] == '0)); // R10
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag[0]) |-> $past(stb.tickLo)); // R3
  AST_HI_QUIET_CHAINED: assert property (@(posedge clk) disable iff (!rstN)
    stb.chained |=> !$rose(matchFlag[1])); // R5
  AST_CAP_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.chained && (capStbLo || capStbHi)) |=> ({capHi, capLo} == $past(cntWide))); // R8
  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr[0] && !setFlag[0]) |=> !matchFlag[0]); // R9

endmodule

// File: rtl/capture_timer16.sv
module capture_timer16
  import ctmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [PRE_W-1:0]  preReload,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  input  logic              runLo,
  input  logic              runHi,
  input  logic              eventIn,
  input  logic              capStbLo,
  input  logic              capStbHi,
  input  logic [1:0]        flagClr,
  output logic [HALF_W-1:0] capLo,
  output logic [HALF_W-1:0] capHi,
  output logic [1:0]        matchFlag
);

  ctmrStb_t stb;

  ctmr_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (ctmrMode_e'(mode)),
    .preReload(preReload),
    .runLo    (runLo),
    .runHi    (runHi),
    .eventIn  (eventIn),
    .stb      (stb)
  );

  ctmr_dpath #(.HALF_W(HALF_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .matchLo  (matchLo),
    .matchHi  (matchHi),
    .capStbLo (capStbLo),
    .capStbHi (capStbHi),
    .flagClr  (flagClr),
    .capLo    (capLo),
    .capHi    (capHi),
    .matchFlag(matchFlag)
  );

endmodule

// File: tb/capture_timer16_test.sv
`timescale 1ns/1ps
module capture_timer16_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] mode;
  logic [7:0] preReload, matchLo, matchHi;
  logic       runLo, runHi, eventIn, capStbLo, capStbHi;
  logic [1:0] flagClr;
  logic [7:0] capLo, capHi;
  logic [1:0] matchFlag;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  capture_timer16 uut (
    .clk(clk), .rstN(rstN), .mode(mode), .preReload(preReload),
    .matchLo(matchLo), .matchHi(matchHi), .runLo(runLo), .runHi(runHi),
    .eventIn(eventIn), .capStbLo(capStbLo), .capStbHi(capStbHi),
    .flagClr(flagClr), .capLo(capLo), .capHi(capHi), .matchFlag(matchFlag)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic capture(input logic lo, input logic hi);
    capStbLo = lo; capStbHi = hi;
    edges(1);
    capStbLo = 1'b0; capStbHi = 1'b0;
  endtask

  task automatic quiesce(input logic [1:0] m, input logic [7:0] p,
                         input logic [7:0] mLo, input logic [7:0] mHi);
    runLo = 0; runHi = 0; eventIn = 0; capStbLo = 0; capStbHi = 0;
    flagClr = 2'b11;
    edges(1);
    flagClr = 2'b00;
    mode = m; preReload = p; matchLo = mLo; matchHi = mHi;
    edges(1);
  endtask

  task automatic tReset();
    check("R1 capLo", capLo, 0);
    check("R1 capHi", capHi, 0);
    check("R1 flags", matchFlag, 0);
  endtask

  task automatic tDualDirect();
    quiesce(2'd0, 8'd0, 8'd5, 8'd9);
    runLo = 1;
    edges(3);
    capture(1, 1);
    check("R2 R7 lo count reload0", capLo, 3);
    check("R10 hi held while stopped", capHi, 0);
  endtask

  task automatic tDualPrescaled();
    quiesce(2'd0, 8'd2, 8'd10, 8'd1);
    runLo = 1; runHi = 1;
    edges(7);
    capture(1, 1);
    check("R2 R3 lo ticks /3", capLo, 2);
    check("R3 hi wrapped", capHi, 0);
    check("R3 hi flag only", matchFlag, 2);
  endtask

  task automatic tClearFlags();
    flagClr = 2'b01;
    edges(1);
    check("R9 zero bit keeps hi flag", matchFlag, 2);
    flagClr = 2'b10;
    edges(1);
    flagClr = 2'b00;
    check("R9 hi flag cleared", matchFlag, 0);
  endtask

  task automatic tMixed();
    quiesce(2'd1, 8'd3, 8'd100, 8'd200);
    runLo = 1; runHi = 1; eventIn = 1;
    edges(5);
    eventIn = 0;
    edges(3);
    capture(1, 1);
    check("R4 lo prescaled", capLo, 2);
    check("R4 hi events", capHi, 5);
  endtask

  task automatic tWide();
    quiesce(2'd2, 8'd0, 8'd2, 8'd1);
    runLo = 1;   // runHi stays low and must be ignored
    edges(256);
    capture(0, 1);
    check("R8 hi strobe loads hi byte", capHi, 1);
    check("R8 R10 hi strobe loads lo byte", capLo, 0);
    check("R5 no flag before 16-bit match", matchFlag, 0);
    edges(43);
    capture(1, 0);
    check("R5 wrapped 16-bit count", {capHi, capLo}, 41);
    check("R5 only flag bit0", matchFlag, 1);
  endtask

  task automatic tEvt16();
    quiesce(2'd3, 8'd5, 8'hFF, 8'hFF);
    runLo = 1; eventIn = 1;
    edges(4);
    eventIn = 0;
    edges(3);
    capture(1, 0);
    check("R6 event count lo", capLo, 4);
    check("R6 event count hi", capHi, 0);
  endtask

  task automatic tStop();
    quiesce(2'd0, 8'd0, 8'd50, 8'd50);
    runLo = 1;
    edges(10);
    runLo = 0;
    edges(2);
    capture(1, 0);
    check("R10 stopped half cleared", capLo, 0);
  endtask

  task automatic tSetWins();
    quiesce(2'd0, 8'd0, 8'd2, 8'd50);
    runLo = 1;
    edges(2);
    flagClr = 2'b01;
    edges(1);
    check("R9 set beats clear", matchFlag[0], 1);
    edges(1);
    flagClr = 2'b00;
    check("R9 lo flag cleared", matchFlag[0], 0);
  endtask

  initial begin
    rstN = 0; mode = 0; preReload = 0; matchLo = 0; matchHi = 0;
    runLo = 0; runHi = 0; eventIn = 0; capStbLo = 0; capStbHi = 0; flagClr = 0;
    edges(3);
    rstN = 1;
    edges(1);
    tReset();
    tDualDirect();
    tDualPrescaled();
    tClearFlags();
    tMixed();
    tWide();
    tEvt16();
    tStop();
    tSetWins();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule